// File: doc/BRIEF.md
# Refractory Leaky Integrate-and-Fire Neuron

This block models one spiking neuron that advances in discrete simulation steps. On each step-enable pulse it moves its membrane potential forward by one forward-Euler step. The derivative is a conductance-based leak toward a reversal potential plus an externally summed synaptic current. That sum is scaled by a precomputed reciprocal of the membrane capacitance and by the step length. All of the arithmetic is signed fixed point. Intermediate products are kept at full width, rounded, and clamped back to the voltage format, so nothing wraps around.

When the integrated potential rises strictly above the threshold input, the neuron does three things. It loads the reset potential, raises a one-clock spike pulse, and enters a refractory regime. In that regime the potential is frozen for a programmed number of steps. There is no hyperpolarisation: the reset value is simply held. A synchronous model-reset input restarts the simulation by loading the reset potential and returning to the integrate regime.

All model parameters are runtime inputs. A surrounding system supplies them, along with the summed synaptic current and the step pulse.

Top module: `lif_neuron`

## Requirements
- R1: After the asynchronous reset `rst_n` is released, `v_mem` is 0 and `spike_o` is 0, and the neuron is in the integrate regime.
- R2: A clock edge with `model_rst` high has the following effects, whatever `step_en` is:
  - `v_mem` is set to `v_reset` for the next cycle;
  - `spike_o` is 0 for the next cycle;
  - the neuron returns to the integrate regime.
- R3: On a clock edge with neither `step_en` nor `model_rst` high, `v_mem` keeps its value.
- R4: A step in the integrate regime that does not fire loads the value v' = sat(v + sat(round((g*(E−v) + I) * k * d / 2^32))). Each quantity has its own format:
  - v, E and the threshold are signed with 24 fractional bits;
  - g is a signed 16-bit value with 8 fractional bits;
  - I is signed 32-bit, in units of 2^-32 of the g·V product;
  - k (reciprocal capacitance) is signed 16-bit;
  - d (step) is signed 16-bit.
  Rounding is half-up, that is, add 2^31 and then floor-shift by 32.
- R5: If the integrated value of R4 is strictly greater than `v_thresh`, the step does not load it. Instead it loads `v_reset`, and `spike_o` is high in the cycle after that step edge. A value equal to the threshold does not fire.
- R6: A spike with `ref_steps` = N > 0 starts a refractory window, using the N sampled at the spike. During the next N step pulses:
  - `v_mem` keeps its value;
  - `spike_o` stays 0.
  The (N+1)th step pulse integrates again.
- R7: A spike with `ref_steps` = 0 leaves the neuron in the integrate regime, so the very next step integrates.
- R8: Both the scaled increment and the final sum are clamped to the 27-bit signed range [−2^26, 2^26−1] instead of wrapping.
- R9: `spike_o` is high only in a cycle that follows an edge where `step_en` was high and `model_rst` was low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| step_en | input | 1 | Simulation step pulse |
| model_rst | input | 1 | Synchronous model restart, loads the reset potential |
| i_syn | input | 32 | Summed synaptic current, signed |
| g_leak | input | 16 | Leak conductance, signed, 8 fractional bits |
| e_leak | input | 27 | Leak reversal potential, signed volts, 24 fractional bits |
| inv_cap | input | 16 | Reciprocal membrane capacitance, signed |
| dt_step | input | 16 | Step length, signed |
| v_thresh | input | 27 | Firing threshold, signed volts, 24 fractional bits |
| v_reset | input | 27 | Reset potential, signed volts, 24 fractional bits |
| ref_steps | input | 16 | Refractory length in steps |
| spike_o | output | 1 | One-cycle spike pulse |
| v_mem | output | 27 | Membrane potential, signed volts, 24 fractional bits |

## Verification
Two situations are hard to reach from the ports: clamping at both ends of the voltage range, and the exact boundary of the refractory window. Extreme reversal potentials with maximal gains are driven directly so that the increment overflows in each direction. The threshold is set to the clamp limit, which shows that an equal value does not fire. For the window, the reversal potential is placed far above threshold so that a spike is certain. Then individual step pulses are counted through a window of known length, and one case uses a zero length. Random parameter sets and idle gaps between steps are also mixed in.

// File: rtl/lif_pkg.sv
package lif_pkg;
  localparam int V_W   = 27;
  localparam int V_F   = 24;
  localparam int G_W   = 16;
  localparam int G_F   = 8;
  localparam int I_W   = 32;
  localparam int K_W   = 16;
  localparam int K_F   = 8;
  localparam int D_W   = 16;
  localparam int D_F   = 16;
  localparam int CNT_W = 16;

  localparam int DIF_W = V_W + 1;
  localparam int P1_W  = DIF_W + G_W;
  localparam int S_W   = ((P1_W > I_W) ? P1_W : I_W) + 1;
  localparam int P3_W  = S_W + K_W + D_W;
  localparam int SH    = G_F + K_F + D_F;

  typedef logic signed [V_W-1:0] volt_t;
  typedef enum logic {INTEG, REFRAC} regime_t;

  localparam logic signed [P3_W-1:0] VMAX_W = P3_W'((64'sd1 <<< (V_W-1)) - 64'sd1);
  localparam logic signed [P3_W-1:0] VMIN_W = -VMAX_W - P3_W'(1);
  localparam logic signed [P3_W-1:0] HALF_W = P3_W'(64'sd1 <<< (SH-1));

  // clamp a wide signed value into the voltage format
  function automatic volt_t sat_v(input logic signed [P3_W-1:0] x);
    volt_t r;
    if (x > VMAX_W)      r = VMAX_W[V_W-1:0];
    else if (x < VMIN_W) r = VMIN_W[V_W-1:0];
    else                 r = x[V_W-1:0];
    return r;
  endfunction

  // one forward-Euler step of the leak plus external current
  function automatic volt_t euler_step(
    input volt_t                    v,
    input volt_t                    e,
    input logic signed [G_W-1:0]    g,
    input logic signed [I_W-1:0]    cur,
    input logic signed [K_W-1:0]    k,
    input logic signed [D_W-1:0]    d
  );
    logic signed [DIF_W-1:0] diff;
    logic signed [P1_W-1:0]  p1;
    logic signed [S_W-1:0]   s;
    logic signed [P3_W-1:0]  p3;
    logic signed [P3_W-1:0]  rnd;
    logic signed [V_W:0]     sum;
    volt_t                   dv;
    diff = DIF_W'(e) - DIF_W'(v);
    p1   = P1_W'(diff) * P1_W'(g);
    s    = S_W'(p1) + S_W'(cur);
    p3   = P3_W'(s) * P3_W'(k) * P3_W'(d);
    rnd  = (p3 + HALF_W) >>> SH;
    dv   = sat_v(rnd);
    sum  = (V_W+1)'(v) + (V_W+1)'(dv);
    return sat_v(P3_W'(sum));
  endfunction
endpackage

// File: rtl/lif_euler.sv
module lif_euler
  import lif_pkg::*;
(
  input  volt_t                 v_cur,
  input  volt_t                 e_leak,
  input  logic signed [G_W-1:0] g_leak,
  input  logic signed [I_W-1:0] i_syn,
  input  logic signed [K_W-1:0] inv_cap,
  input  logic signed [D_W-1:0] dt_step,
  input  volt_t                 v_thresh,
  output volt_t                 v_integ,
  output logic                  over_thr
);
  logic signed [DIF_W-1:0] margin;

  always_comb begin
    v_integ  = euler_step(v_cur, e_leak, g_leak, i_syn, inv_cap, dt_step);
    margin   = DIF_W'(v_integ) - DIF_W'(v_thresh);
    over_thr = (margin > DIF_W'(0));
  end
endmodule

// File: rtl/lif_regime.sv
module lif_regime
  import lif_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             model_rst,
  input  logic             step_en,
  input  logic             over_thr,
  input  logic [CNT_W-1:0] ref_steps,
  output logic             fire,
  output logic             in_ref,
  output logic             ref_done
);
  regime_t          st;
  logic [CNT_W-1:0] cnt;

  assign in_ref   = (st == REFRAC);
  assign ref_done = (cnt == CNT_W'(1));
  assign fire     = step_en & ~model_rst & ~in_ref & over_thr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= INTEG;
      cnt <= '0;
    end else if (model_rst) begin
      st  <= INTEG;
      cnt <= '0;
    end else if (fire) begin
      if (ref_steps != '0) begin
        st  <= REFRAC;
        cnt <= ref_steps;
      end
    end else if (step_en && in_ref) begin
      if (ref_done) begin
        st  <= INTEG;
        cnt <= '0;
      end else begin
        cnt <= cnt - CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/lif_neuron.sv
module lif_neuron
  import lif_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  step_en,
  input  logic                  model_rst,
  input  logic signed [31:0]    i_syn,
  input  logic signed [15:0]    g_leak,
  input  logic signed [26:0]    e_leak,
  input  logic signed [15:0]    inv_cap,
  input  logic signed [15:0]    dt_step,
  input  logic signed [26:0]    v_thresh,
  input  logic signed [26:0]    v_reset,
  input  logic [15:0]           ref_steps,
  output logic                  spike_o,
  output logic signed [26:0]    v_mem
);
  volt_t v_q;
  volt_t v_integ;
  logic  over_thr;
  logic  fire;
  logic  in_ref;
  logic  ref_done;

  lif_euler u_euler (
    .v_cur    (v_q),
    .e_leak   (e_leak),
    .g_leak   (g_leak),
    .i_syn    (i_syn),
    .inv_cap  (inv_cap),
    .dt_step  (dt_step),
    .v_thresh (v_thresh),
    .v_integ  (v_integ),
    .over_thr (over_thr)
  );

  lif_regime u_regime (
    .clk       (clk),
    .rst_n     (rst_n),
    .model_rst (model_rst),
    .step_en   (step_en),
    .over_thr  (over_thr),
    .ref_steps (ref_steps),
    .fire      (fire),
    .in_ref    (in_ref),
    .ref_done  (ref_done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_q     <= '0;
      spike_o <= 1'b0;
    end else begin
      spike_o <= fire;
      if (model_rst || fire) v_q <= v_reset;
      else if (step_en && !in_ref) v_q <= v_integ;
    end
  end

  assign v_mem = v_q;
endmodule

// File: rtl/lif_neuron_chk.sv
module lif_neuron_chk (
  input logic               clk,
  input logic               rst_n,
  input logic               step_en,
  input logic               model_rst,
  input logic signed [26:0] v_reset,
  input logic               spike_o,
  input logic signed [26:0] v_mem,
  input logic               in_ref,
  input logic               ref_done
);
  // R2: model restart loads the reset potential and clears the spike
  a_r2_model_reset: assert property (@(posedge clk) disable iff (!rst_n)
    model_rst |=> (v_mem == $past(v_reset)) && !spike_o);

  // R3: no step and no restart leaves the potential alone
  a_r3_hold_no_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!step_en && !model_rst) |=> $stable(v_mem));

  // R6: a step inside the refractory window freezes the potential
  a_r6_refractory_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ref && step_en && !model_rst) |=> ($stable(v_mem) && !spike_o));

  // R6: the final step of the window leaves the refractory regime
  a_r6_window_exit: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ref && ref_done && step_en && !model_rst) |=> !in_ref);

  // R5: a spike is accompanied by the reset potential
  a_r5_spike_loads_reset: assert property (@(posedge clk) disable iff (!rst_n)
    spike_o |-> (v_mem == $past(v_reset)));

  // R9: a spike only follows a real step edge
  a_r9_spike_after_step: assert property (@(posedge clk) disable iff (!rst_n)
    spike_o |-> ($past(step_en) && !$past(model_rst)));
endmodule

bind lif_neuron lif_neuron_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .step_en   (step_en),
  .model_rst (model_rst),
  .v_reset   (v_reset),
  .spike_o   (spike_o),
  .v_mem     (v_mem),
  .in_ref    (in_ref),
  .ref_done  (ref_done)
);

// File: tb/lif_neuron_tb.sv
`timescale 1ns/1ps
module lif_neuron_tb;
  localparam int VHI = 67108863;
  localparam int VLO = -67108864;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic step_en = 1'b0;
  logic model_rst = 1'b0;
  logic signed [31:0] i_syn = '0;
  logic signed [15:0] g_leak = '0;
  logic signed [26:0] e_leak = '0;
  logic signed [15:0] inv_cap = '0;
  logic signed [15:0] dt_step = '0;
  logic signed [26:0] v_thresh = '0;
  logic signed [26:0] v_reset = '0;
  logic [15:0] ref_steps = '0;
  logic spike_o;
  logic signed [26:0] v_mem;

  int errors = 0;
  int checks = 0;
  int m_v = 0;
  bit m_ref = 0;
  int m_cnt = 0;
  bit m_spk = 0;

  always #4 clk = ~clk;

  lif_neuron u_dut (
    .clk(clk), .rst_n(rst_n), .step_en(step_en), .model_rst(model_rst),
    .i_syn(i_syn), .g_leak(g_leak), .e_leak(e_leak), .inv_cap(inv_cap),
    .dt_step(dt_step), .v_thresh(v_thresh), .v_reset(v_reset),
    .ref_steps(ref_steps), .spike_o(spike_o), .v_mem(v_mem)
  );

  function automatic longint clamp(input logic signed [127:0] x);
    if (x > 128'sd67108863) return 64'sd67108863;
    if (x < -128'sd67108864) return -64'sd67108864;
    return longint'(x);
  endfunction

  function automatic int model_euler(input int v);
    longint diff, p1, s;
    logic signed [127:0] big;
    longint q;
    diff = longint'(int'(e_leak)) - longint'(v);
    p1   = diff * longint'(int'(g_leak));
    s    = p1 + longint'(int'(i_syn));
    big  = 128'(s) * 128'(int'(inv_cap)) * 128'(int'(dt_step));
    big  = (big + (128'sd1 <<< 31)) >>> 32;
    q    = clamp(big);
    return int'(clamp(128'(longint'(v) + q)));
  endfunction

  task automatic check_v(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s v_mem actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic check_b(input string tag, input bit act, input bit exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s spike_o actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_step(input string tag);
    int vi;
    step_en = 1'b1;
    @(negedge clk);
    step_en = 1'b0;
    m_spk = 0;
    if (m_ref) begin
      if (m_cnt <= 1) m_ref = 0;
      else m_cnt--;
    end else begin
      vi = model_euler(m_v);
      if (vi > int'(v_thresh)) begin
        m_v = int'(v_reset);
        m_spk = 1;
        if (ref_steps != 0) begin
          m_ref = 1;
          m_cnt = int'(ref_steps);
        end
      end else begin
        m_v = vi;
      end
    end
    check_v(tag, int'(v_mem), m_v);
    check_b(tag, spike_o, m_spk);
  endtask

  task automatic do_mreset(input string tag, input bit with_step);
    model_rst = 1'b1;
    step_en = with_step;
    @(negedge clk);
    model_rst = 1'b0;
    step_en = 1'b0;
    m_v = int'(v_reset);
    m_ref = 0;
    m_cnt = 0;
    check_v(tag, int'(v_mem), m_v);
    check_b(tag, spike_o, 1'b0);
  endtask

  task automatic idle(input int n, input string tag);
    for (int j = 0; j < n; j++) begin
      @(negedge clk);
      check_v(tag, int'(v_mem), m_v);
      check_b(tag, spike_o, 1'b0);
    end
  endtask

  task automatic report();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    int seed;
    int r;
    seed = $urandom(32'h5eed1234);
    repeat (3) @(negedge clk);
    // R1: reset state
    check_v("R1", int'(v_mem), 0);
    check_b("R1", spike_o, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check_v("R1", int'(v_mem), 0);
    check_b("R1", spike_o, 1'b0);

    // directed leak below threshold
    v_thresh = -27'sd922747;
    v_reset = -27'sd1174405;
    e_leak = -27'sd1090000;
    g_leak = 16'sd200; inv_cap = 16'sd300; dt_step = 16'sd800;
    i_syn = 32'sd0; ref_steps = 16'd3;
    do_mreset("R2", 1'b0);
    idle(2, "R3");
    for (int n = 0; n < 4; n++) do_step("R4");
    i_syn = -32'sd50000000;
    for (int n = 0; n < 3; n++) do_step("R4");

    // R5/R6: force a spike, window of 3
    i_syn = 32'sd0;
    e_leak = 27'sd8000000;
    g_leak = 16'sd4000; inv_cap = 16'sd4000;
    do_step("R5");
    if (m_spk != 1) begin errors++; $display("FAIL R5 stimulus produced no spike actual=0 expected=1"); end
    checks++;
    idle(1, "R9");
    for (int n = 0; n < 3; n++) do_step("R6");
    do_step("R6");

    // R7: zero-length window
    do_mreset("R2", 1'b1);
    ref_steps = 16'd0;
    do_step("R7");
    do_step("R7");
    do_step("R7");

    // R8: clamp at both ends, threshold equal to max does not fire
    v_reset = 27'sd0;
    v_thresh = 27'(VHI);
    do_mreset("R2", 1'b0);
    e_leak = 27'(VHI); g_leak = 16'sd32767; inv_cap = 16'sd32767; dt_step = 16'sd32767;
    i_syn = 32'sd2147483647;
    do_step("R8"); do_step("R8");
    check_v("R8", int'(v_mem), VHI);
    check_b("R5", spike_o, 1'b0);
    e_leak = 27'(VLO); i_syn = -32'sd2147483647;
    do_step("R8"); do_step("R8");
    check_v("R8", int'(v_mem), VLO);

    // random mix
    for (int n = 0; n < 1500; n++) begin
      r = int'($urandom % 16);
      if (r == 0) begin
        v_reset = 27'(-1174405 + int'($urandom % 200000));
        do_mreset("R2", ($urandom % 2) == 1);
      end else if (r < 3) begin
        v_thresh = 27'(-922747 + int'($urandom % 100000) - 50000);
        e_leak = 27'(-1200000 + int'($urandom % 3200000));
        g_leak = 16'(int'($urandom % 4096));
        inv_cap = 16'(int'($urandom % 4096));
        dt_step = 16'(int'($urandom % 4096));
        i_syn = 32'(int'($urandom % 32'h2000_0000) - 32'sh1000_0000);
        ref_steps = 16'($urandom % 6);
      end else begin
        do_step("R4");
        if (($urandom % 4) == 0) idle(1, "R3");
      end
    end
    report();
  end
endmodule